// File: doc/BRIEF.md
# Multi-Lane TDM/I2S Audio Serializer

This block sends PCM playback samples as a serial audio stream. It produces a bit clock, a frame clock and up to four serial data lanes. A single framing engine covers two modes. The first is stereo I2S, where each lane carries one channel pair. The second is TDM with 2, 4 or 8 slots, all on lane 0, framed by a short sync pulse.

The bit clock comes from a programmable divider on the master clock. A parallel bank of eight 32-bit sample words is captured at the start of every frame. The words go out MSB first and left-justified in the slot. When the word is shorter than the slot, the tail of the slot is filled with zeros. Each lane picks its starting channel pair, or it can be forced silent.

Static fields set the format, word length, slot width, slot count, frame-clock pulse width, one-bit data delay and the polarity of both clocks. If no fresh sample set is offered when a frame begins, the previous set is sent again and a sticky underrun flag is raised.

Top module: `tdm_serializer`

## Requirements
- R1: `cfg_tdm`=0 selects I2S framing: 2 slots per frame, and every lane may carry data. `cfg_tdm`=1 selects TDM framing. In TDM the `cfg_slots` field sets the slot count (0→2, 1→4, 2 or 3→8), only lane 0 carries data, and lanes 1–3 output 0.
- R2: `cfg_slot_bck` sets the bit clocks per slot (0→16, 1→24, 2 or 3→32). A frame lasts slot count × slot width bit clocks.
- R3: `cfg_wlen` sets the word length: bit 1 set → 32 bits, otherwise 16 bits, taken from the low half of the sample word. Words go out MSB first from the first bit of the slot. Slot bits past the word are 0, and word bits past the slot are dropped.
- R4: Lane L reads its 3-bit selector at `cfg_lane_start[3L+2:3L]`. A selector value of 4–7 makes the lane output 0. Otherwise slot s of the lane carries channel (2·selector + s) mod 8. Channel c is `smp_data[32c+31:32c]`.
- R5: Before inversion, the frame clock is high on frame bit positions 0 through `cfg_lr_width` and low on the other positions.
- R6: With `cfg_delay`=1 every lane lags its frame position by one bit clock, and the first bit after enable is 0. With `cfg_delay`=0 there is no lag.
- R7: `bck` is the internal bit clock XOR `cfg_bck_inv`, and `lrck` is the internal frame clock XOR `cfg_lrck_inv`. Data and frame clock change on the internal falling edge, so they are stable at the internal rising edge.
- R8: Each bit-clock half period lasts `cfg_div`+1 master clock cycles.
- R9: The sample bank is captured on the first bit of each frame, and `frame_start` pulses for one cycle just after. If `smp_valid` is low at that moment, the previous bank is repeated and `underrun` is set, staying set until reset.
- R10: While `en` is low, `bck` rests at 1 XOR `cfg_bck_inv`, `lrck` at `cfg_lrck_inv`, and every lane at 0. After `en` rises, the first internal falling edge starts frame bit position 0.
- R11: After reset, the outputs are in the idle state of R10 and `underrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Serializer run enable |
| cfg_tdm | input | 1 | 0 = I2S framing, 1 = TDM framing |
| cfg_wlen | input | 2 | Word length code |
| cfg_slot_bck | input | 2 | Bit clocks per slot code |
| cfg_slots | input | 2 | TDM slot count code |
| cfg_lr_width | input | 8 | Last frame position with frame clock high |
| cfg_delay | input | 1 | One-bit data delay |
| cfg_bck_inv | input | 1 | Bit clock polarity invert |
| cfg_lrck_inv | input | 1 | Frame clock polarity invert |
| cfg_div | input | DIV_W | Bit clock half period minus one, in master cycles |
| cfg_lane_start | input | 3*LANES | Start pair selector per lane |
| smp_data | input | 256 | Eight 32-bit channel words |
| smp_valid | input | 1 | A fresh sample bank is offered |
| frame_start | output | 1 | Bank capture strobe |
| underrun | output | 1 | Sticky missed-bank flag |
| bck | output | 1 | Bit clock |
| lrck | output | 1 | Frame clock |
| sdata | output | LANES | Serial data lanes |

## Verification
Every serial result appears one master cycle after the internal falling edge that starts its bit. The bench therefore never counts cycles to find a bit. It reads `lrck` and `sdata` on the falling master edge that first shows the internal bit clock high, which is mid-bit, half a bit period after the change. `frame_start` is seen on the falling edge one cycle after capture, and the next bank is driven there, a full frame before it is needed. The period check, the idle checks and the underrun check are sampled on falling edges after the related transition.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    localparam int unsigned CHANS  = 8;
    localparam int unsigned SMP_W  = 32;
    localparam int unsigned POS_W  = 9;
    localparam int unsigned SLOT_W = 3;
    localparam int unsigned BIT_W  = 5;

    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_TDM = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [SLOT_W-1:0] slot;
        logic [BIT_W-1:0]  bis;
    } frame_pos_t;

    function automatic logic [5:0] slot_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd16;
            2'd1:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [3:0] slot_count(input fmt_e fmt, input logic [1:0] code);
        if (fmt == FMT_I2S) return 4'd2;
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [5:0] word_bits(input logic [1:0] code);
        return code[1] ? 6'd32 : 6'd16;
    endfunction

    function automatic logic [POS_W-1:0] frame_len(input fmt_e fmt, input logic [1:0] slots,
                                                   input logic [1:0] sbck);
        return POS_W'(slot_count(fmt, slots)) * POS_W'(slot_bits(sbck));
    endfunction

endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bck_int,
    output logic             launch
);
    logic [DIV_W-1:0] dcnt;
    logic             wrap;

    assign wrap   = (dcnt == div);
    assign launch = en && wrap && bck_int;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dcnt    <= '0;
            bck_int <= 1'b1;
        end else if (wrap) begin
            dcnt    <= '0;
            bck_int <= ~bck_int;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    // R8
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> !bck_int);

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       launch,
    input  fmt_e       fmt,
    input  logic [1:0] slots,
    input  logic [1:0] sbck,
    output frame_pos_t fp,
    output logic       frame_tick,
    output logic       step_q
);
    logic             run;
    logic [POS_W-1:0] flen;
    logic [POS_W-1:0] pos_nxt;
    logic [5:0]       sb;

    assign flen       = frame_len(fmt, slots, sbck);
    assign sb         = slot_bits(sbck);
    assign pos_nxt    = (!run || fp.pos >= flen - 1'b1) ? '0 : fp.pos + 1'b1;
    assign frame_tick = launch && (pos_nxt == '0);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run <= 1'b0;
            fp  <= '0;
        end else if (launch) begin
            run    <= 1'b1;
            fp.pos <= pos_nxt;
            if (pos_nxt == '0) begin
                fp.slot <= '0;
                fp.bis  <= '0;
            end else if ({1'b0, fp.bis} == sb - 6'd1) begin
                fp.bis  <= '0;
                fp.slot <= fp.slot + 1'b1;
            end else begin
                fp.bis <= fp.bis + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= 1'b0;
        else     step_q <= launch;
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (fp.pos < flen));

endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_ser_pkg::*;
#(
    parameter int unsigned LANE = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    step,
    input  fmt_e                    fmt,
    input  logic [1:0]              wlen,
    input  logic                    delay,
    input  logic [2:0]              start_sel,
    input  logic [SLOT_W-1:0]       slot,
    input  logic [BIT_W-1:0]        bis,
    input  logic [CHANS*SMP_W-1:0]  bank,
    output logic                    sdata
);
    logic             lane_on;
    logic [2:0]       ch;
    logic [SMP_W-1:0] word;
    logic [5:0]       wb;
    logic [5:0]       idx;
    logic             bit_now;
    logic             bit_prev;

    assign lane_on = !start_sel[2] && ((fmt == FMT_I2S) || (LANE == 0));
    assign ch      = {start_sel[1:0], 1'b0} + slot;
    assign word    = bank[ch*SMP_W +: SMP_W];
    assign wb      = word_bits(wlen);
    assign idx     = wb - 6'd1 - {1'b0, bis};
    assign bit_now = lane_on && ({1'b0, bis} < wb) && word[idx[4:0]];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sdata    <= 1'b0;
            bit_prev <= 1'b0;
        end else if (step) begin
            sdata    <= delay ? bit_prev : bit_now;
            bit_prev <= bit_now;
        end
    end

    // R10
    lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sdata == 1'b0));

endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
    import tdm_ser_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DIV_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   cfg_tdm,
    input  logic [1:0]             cfg_wlen,
    input  logic [1:0]             cfg_slot_bck,
    input  logic [1:0]             cfg_slots,
    input  logic [7:0]             cfg_lr_width,
    input  logic                   cfg_delay,
    input  logic                   cfg_bck_inv,
    input  logic                   cfg_lrck_inv,
    input  logic [DIV_W-1:0]       cfg_div,
    input  logic [3*LANES-1:0]     cfg_lane_start,
    input  logic [CHANS*SMP_W-1:0] smp_data,
    input  logic                   smp_valid,
    output logic                   frame_start,
    output logic                   underrun,
    output logic                   bck,
    output logic                   lrck,
    output logic [LANES-1:0]       sdata
);
    fmt_e                   fmt;
    logic                   bck_int;
    logic                   launch;
    logic                   frame_tick;
    logic                   step_q;
    frame_pos_t             fp;
    logic [CHANS*SMP_W-1:0] bank;

    assign fmt = cfg_tdm ? FMT_TDM : FMT_I2S;

    tdm_bitclk #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .div     (cfg_div),
        .bck_int (bck_int),
        .launch  (launch)
    );

    tdm_framer u_frm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .launch     (launch),
        .fmt        (fmt),
        .slots      (cfg_slots),
        .sbck       (cfg_slot_bck),
        .fp         (fp),
        .frame_tick (frame_tick),
        .step_q     (step_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bank     <= '0;
            underrun <= 1'b0;
        end else if (frame_tick) begin
            if (smp_valid) bank     <= smp_data;
            else           underrun <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) frame_start <= 1'b0;
        else     frame_start <= frame_tick;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            bck  <= ~cfg_bck_inv;
            lrck <= cfg_lrck_inv;
        end else begin
            bck <= bck_int ^ cfg_bck_inv;
            if (step_q) lrck <= (fp.pos <= POS_W'(cfg_lr_width)) ^ cfg_lrck_inv;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tdm_lane #(.LANE(g)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .en        (en),
            .step      (step_q),
            .fmt       (fmt),
            .wlen      (cfg_wlen),
            .delay     (cfg_delay),
            .start_sel (cfg_lane_start[3*g +: 3]),
            .slot      (fp.slot),
            .bis       (fp.bis),
            .bank      (bank),
            .sdata     (sdata[g])
        );
    end

    // R9
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R9
    take_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> $past(en));

    // R10
    bck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (bck == ~cfg_bck_inv));

endmodule

// File: tb/sim_tdm_serializer.sv
module sim_tdm_serializer;
    localparam int LANES = 4;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst = 1'b1, en = 1'b0;
    logic                 cfg_tdm = 0, cfg_delay = 0, cfg_bck_inv = 0, cfg_lrck_inv = 0;
    logic [1:0]           cfg_wlen = 0, cfg_slot_bck = 0, cfg_slots = 0;
    logic [7:0]           cfg_lr_width = 0;
    logic [DIV_W-1:0]     cfg_div = 0;
    logic [3*LANES-1:0]   cfg_lane_start = 0;
    logic [255:0]         smp_data = 0;
    logic                 smp_valid = 0;
    logic                 frame_start, underrun, bck, lrck;
    logic [LANES-1:0]     sdata;

    tdm_serializer #(.LANES(LANES), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .en(en), .cfg_tdm(cfg_tdm), .cfg_wlen(cfg_wlen),
        .cfg_slot_bck(cfg_slot_bck), .cfg_slots(cfg_slots), .cfg_lr_width(cfg_lr_width),
        .cfg_delay(cfg_delay), .cfg_bck_inv(cfg_bck_inv), .cfg_lrck_inv(cfg_lrck_inv),
        .cfg_div(cfg_div), .cfg_lane_start(cfg_lane_start), .smp_data(smp_data),
        .smp_valid(smp_valid), .frame_start(frame_start), .underrun(underrun),
        .bck(bck), .lrck(lrck), .sdata(sdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: cycles actual %0d expected below 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    logic [31:0]      dat [0:7][0:7];
    logic [31:0]      eb  [0:7][0:7];
    logic             cap_lr [0:2047];
    logic [LANES-1:0] cap_sd [0:2047];
    int t_tdm, t_wl, t_sb, t_sl, t_st [4];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sbits(int code);
        return (code == 0) ? 16 : (code == 1) ? 24 : 32;
    endfunction

    function automatic int nslots(int tdm, int code);
        if (tdm == 0) return 2;
        return (code == 0) ? 2 : (code == 1) ? 4 : 8;
    endfunction

    function automatic logic [255:0] pack(int f);
        logic [255:0] v;
        for (int c = 0; c < 8; c++) v[c*32 +: 32] = dat[f][c];
        return v;
    endfunction

    function automatic logic exp_bit(int lane, int j);
        int sb, fl, f, p, s, b, w, ch, sel;
        sb  = sbits(t_sb);
        fl  = nslots(t_tdm, t_sl) * sb;
        f   = j / fl;
        p   = j % fl;
        s   = p / sb;
        b   = p % sb;
        sel = t_st[lane];
        if (sel >= 4) return 1'b0;
        if (t_tdm != 0 && lane > 0) return 1'b0;
        ch = (2 * sel + s) % 8;
        w  = (t_wl >= 2) ? 32 : 16;
        if (b >= w) return 1'b0;
        return eb[f][ch][w-1-b];
    endfunction

    task automatic run_test(input int tdm, wl, sb, sl, lrw, dly, bi, li, dv,
                            input int s0, s1, s2, s3, input int nf, input logic [7:0] vm);
        int fl, nbits, pulses, cnt, last_rise, per_bad, bad_at;
        logic prev_int, cur_int, e;
        bit exp_urun;
        rst = 1'b1; en = 1'b0;
        cfg_tdm = tdm[0]; cfg_wlen = wl[1:0]; cfg_slot_bck = sb[1:0]; cfg_slots = sl[1:0];
        cfg_lr_width = lrw[7:0]; cfg_delay = dly[0]; cfg_bck_inv = bi[0]; cfg_lrck_inv = li[0];
        cfg_div = dv[DIV_W-1:0];
        cfg_lane_start = {s3[2:0], s2[2:0], s1[2:0], s0[2:0]};
        t_tdm = tdm; t_wl = wl; t_sb = sb; t_sl = sl;
        t_st[0] = s0; t_st[1] = s1; t_st[2] = s2; t_st[3] = s3;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bck == ~bi[0] && lrck == li[0] && sdata == '0 && !underrun && !frame_start,
            "R11", "reset outputs", {bck, lrck, sdata, underrun}, {~bi[0], li[0], 4'b0, 1'b0});
        rst = 1'b0;
        exp_urun = 0;
        for (int f = 0; f < nf; f++) begin
            for (int c = 0; c < 8; c++) dat[f][c] = $urandom;
            for (int c = 0; c < 8; c++) eb[f][c] = (f == 0 || vm[f]) ? dat[f][c] : eb[f-1][c];
            if (f > 0 && !vm[f]) exp_urun = 1;
        end
        fl = nslots(tdm, sl) * sbits(sb);
        smp_data = pack(0); smp_valid = 1'b1;
        @(negedge clk);
        en = 1'b1;
        nbits = 0; pulses = 0; cnt = 0; last_rise = -1; per_bad = 0; prev_int = 1'b1;
        while (nbits < nf * fl) begin
            @(negedge clk);
            cnt++;
            if (frame_start) begin
                pulses++;
                if (pulses < nf) begin smp_data = pack(pulses); smp_valid = vm[pulses]; end
                else smp_valid = 1'b1;
            end
            cur_int = bck ^ bi[0];
            if (!prev_int && cur_int) begin
                cap_lr[nbits] = lrck;
                cap_sd[nbits] = sdata;
                if (last_rise >= 0 && cnt - last_rise != 2 * (dv + 1)) per_bad++;
                last_rise = cnt;
                nbits++;
            end
            prev_int = cur_int;
        end
        en = 1'b0;
        // R2/R5/R7 frame clock shape and polarity
        bad_at = -1;
        for (int k = 0; k < nbits; k++) begin
            e = (((k % fl) <= lrw) ? 1'b1 : 1'b0) ^ li[0];
            if (cap_lr[k] !== e && bad_at < 0) bad_at = k;
        end
        chk(bad_at < 0, "R2/R5/R7", "lrck first bad bit index", bad_at, -1);
        // R1/R3/R4/R6/R9 lane data
        for (int L = 0; L < LANES; L++) begin
            bad_at = -1;
            for (int k = 0; k < nbits; k++) begin
                e = (k < dly) ? 1'b0 : exp_bit(L, k - dly);
                if (cap_sd[k][L] !== e && bad_at < 0) bad_at = k;
            end
            chk(bad_at < 0, "R1/R3/R4/R6/R9", $sformatf("lane %0d first bad bit index", L),
                bad_at, -1);
        end
        // R8 bit clock half period
        chk(per_bad == 0, "R8", "bit periods off", per_bad, 0);
        // R9 underrun flag
        chk(underrun == exp_urun, "R9", "underrun", underrun, exp_urun);
        repeat (3) @(negedge clk);
        // R10 idle after disable
        chk(bck == ~bi[0] && lrck == li[0] && sdata == '0, "R10", "idle outputs",
            {bck, lrck, sdata}, {~bi[0], li[0], 4'b0});
    endtask

    initial begin
        int tdm, sb, sl, fl;
        void'($urandom(32'd20240611));
        // I2S 16-bit, two lanes, data delay
        run_test(0, 1, 0, 0, 15, 1, 0, 0, 0, 0, 1, 4, 4, 3, 8'hFF);
        // I2S 32-bit, four lanes, both clocks inverted, one missed bank
        run_test(0, 2, 2, 0, 31, 1, 1, 1, 1, 0, 1, 2, 3, 4, 8'b1111_1011);
        // TDM 8 slots, lane 1 selector ignored in TDM
        run_test(1, 2, 2, 2, 0, 0, 0, 0, 0, 0, 1, 2, 3, 2, 8'hFF);
        // TDM 4 slots, 16-bit word in 24-bit slot, start at pair 4/5
        run_test(1, 1, 1, 1, 0, 0, 0, 1, 2, 2, 4, 4, 4, 3, 8'hFF);
        // I2S 32-bit word truncated to 24-bit slot, mixed selectors
        run_test(0, 3, 1, 0, 23, 1, 1, 0, 0, 3, 2, 7, 5, 3, 8'hFF);
        // TDM 2 slots with lane 0 forced to zero
        run_test(1, 1, 0, 0, 0, 0, 0, 0, 3, 4, 0, 1, 2, 2, 8'hFF);
        for (int i = 0; i < 4; i++) begin
            tdm = $urandom % 2;
            sb  = $urandom % 4;
            sl  = $urandom % 4;
            fl  = nslots(tdm, sl) * sbits(sb);
            run_test(tdm, $urandom % 4, sb, sl, $urandom % fl, $urandom % 2, $urandom % 2,
                     $urandom % 2, $urandom % 3, $urandom % 8, $urandom % 8, $urandom % 8,
                     $urandom % 8, 3, {5'b11111, 1'($urandom % 2), 2'b11});
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule